// File: doc/BRIEF.md
# LZ77 Stream Decompressor

This block expands an LZ77-compressed byte stream back into its original bytes. Compressed bytes enter on a valid/ready byte input. The first four bytes form a header word, least significant byte first. The header carries the number of bytes to be produced. After the header, tokens follow in groups of up to eight, and each group is preceded by one flag byte. A token is either a literal byte or a two-byte back-reference into the bytes already produced. The reference is resolved against an internal circular history of the most recent output bytes.

Decoded data leaves on a valid/ready output that is 16 bits wide. In byte mode each transfer carries one byte. In halfword mode, consecutive byte pairs are packed into one transfer. A start pulse begins a new stream. The block stops exactly at the declared length, reports completion, and flags a back-reference that the length cut short.

Top module: `lz_stream_inflate`

## Requirements
- R1: After reset, and until a start pulse, in_ready, out_valid, done and error are all 0. A start pulse clears all progress and begins header collection in the next cycle.
- R2: The header is four bytes, least significant first. Header bits 31:8 give the output length in bytes, and the first byte (bits 7:0) is accepted but not checked. A length of 0 raises done with no output.
- R3: Each flag byte governs the next 8 tokens, and its bits are used from bit 7 down to bit 0. A flag bit of 0 selects a literal token; a flag bit of 1 selects a reference token. After 8 tokens the next input byte is taken as a new flag byte.
- R4: A literal token is one input byte, which becomes the next output byte unchanged.
- R5: A reference token is two input bytes, high byte first. The copy length is bits 15:12 plus 3. The displacement is bits 11:0 plus 1, counted back from the current output position.
- R6: A reference copies one byte at a time, so a displacement smaller than the copy length repeats the most recent bytes.
- R7: Output stops exactly when the declared length is reached, even inside a reference. Any remaining input, including unused flag bits, is ignored: in_ready stays 0 and no further output appears until the next start.
- R8: error is set when the length ends a reference before its last byte. A reference that ends exactly on the final byte leaves error at 0.
- R9: in_ready is 0 while a reference copy is being produced.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R11: In byte mode (half_mode = 0), each transfer carries one output byte in out_data[7:0], with out_data[15:8] = 0, in output order.
- R12: In halfword mode (half_mode = 1), the byte at an even output position goes in out_data[7:0] and the following odd byte goes in out_data[15:8] of the same transfer. A final byte at an even position is sent alone with out_data[15:8] = 0. half_mode is held steady for the whole stream.
- R13: done rises once the last output byte has been taken into the output stage, and stays high until the next start. error is only ever 1 while done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new stream |
| half_mode | input | 1 | 1 = halfword packing, 0 = byte output |
| in_valid | input | 1 | Compressed byte available |
| in_data | input | 8 | Compressed byte |
| in_ready | output | 1 | Block accepts in_data this cycle |
| out_valid | output | 1 | Decoded item available |
| out_data | output | 16 | Decoded byte or halfword |
| out_ready | input | 1 | Consumer accepts out_data this cycle |
| done | output | 1 | Declared length fully produced |
| error | output | 1 | A reference was cut short by the length |

## Verification
A wrong history index or displacement shows up at the ports as a wrong byte on the first copied transfer after the faulty reference. The expected data never comes from the history, so such an error cannot hide. A flag bit taken in the wrong order turns a literal into a reference, or the reverse. This desynchronises the input, and within a few bytes the output diverges or the length is never reached. A miscounted length shows as missing or extra transfers, or as a wrong value of done or error at the end of the stream. Packing faults show on the first halfword, and backpressure faults show in the first stalled cycle.

// File: rtl/lzi_pkg.sv
package lzi_pkg;

   // header length field width (bits 31:8 of the header word)
   localparam int LZI_LEN_W = 24;
   // reference token: 4-bit length code, 12-bit distance code
   localparam int LZI_TOK_LEN_W  = 4;
   localparam int LZI_TOK_DIST_W = 12;
   localparam int LZI_MIN_COPY   = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_FLAG,
      ST_TOKEN,
      ST_REFLO,
      ST_COPY,
      ST_DONE
   } lzi_state_e;

endpackage

// File: rtl/lzi_hist_ram.sv
module lzi_hist_ram #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   // read-during-copy sees every byte written on an earlier edge
   assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/lzi_ctrl.sv
module lzi_ctrl
   import lzi_pkg::*;
#(
   parameter int HIST_AW = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   output logic               in_ready,
   output logic               byte_vld,
   output logic [7:0]         byte_dat,
   input  logic               byte_rdy,
   output logic               byte_last,
   output logic               byte_pos0,
   output logic               hist_wr_en,
   output logic [HIST_AW-1:0] hist_wr_addr,
   output logic [7:0]         hist_wr_data,
   output logic [HIST_AW-1:0] hist_rd_addr,
   input  logic [7:0]         hist_rd_data,
   output logic               done,
   output logic               error
);

   localparam int LW    = LZI_LEN_W;
   localparam int DW    = HIST_AW + 1;
   localparam int CW    = LZI_TOK_LEN_W + 1;
   localparam int TOK_W = LZI_TOK_LEN_W + LZI_TOK_DIST_W;

   lzi_state_e        state_q;
   logic [1:0]        hdr_cnt_q;
   logic [LW-1:0]     len_q;
   logic [LW-1:0]     out_cnt_q;
   logic [7:0]        flag_q;
   logic [3:0]        flag_cnt_q;
   logic [7:0]        ref_hi_q;
   logic [CW-1:0]     copy_left_q;
   logic [DW-1:0]     disp_q;
   logic              err_q;

   logic              lit_sel;
   logic              accept_in;
   logic              produce;
   logic [LW-1:0]     cnt_next;
   logic [LW-1:0]     len_hdr;
   logic [TOK_W-1:0]  tok_word;
   lzi_state_e        tok_next;

   always_comb begin
      lit_sel   = (state_q == ST_TOKEN) && !flag_q[7];
      byte_vld  = (lit_sel && in_valid) || (state_q == ST_COPY);
      byte_dat  = (state_q == ST_COPY) ? hist_rd_data : in_data;
      in_ready  = (state_q == ST_HDR) || (state_q == ST_FLAG) ||
                  (state_q == ST_REFLO) ||
                  ((state_q == ST_TOKEN) && (flag_q[7] || byte_rdy));
      accept_in = in_valid && in_ready;
      produce   = byte_vld && byte_rdy;
      cnt_next  = out_cnt_q + 1'b1;
      byte_last = (cnt_next == len_q);
      byte_pos0 = out_cnt_q[0];
      len_hdr   = {in_data, len_q[LW-1:8]};
      tok_word  = {ref_hi_q, in_data};
      tok_next  = (flag_cnt_q == 4'd1) ? ST_FLAG : ST_TOKEN;
   end

   assign hist_wr_en   = produce;
   assign hist_wr_addr = out_cnt_q[HIST_AW-1:0];
   assign hist_wr_data = byte_dat;
   assign hist_rd_addr = out_cnt_q[HIST_AW-1:0] - disp_q[HIST_AW-1:0];

   assign done  = (state_q == ST_DONE);
   assign error = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         hdr_cnt_q   <= '0;
         len_q       <= '0;
         out_cnt_q   <= '0;
         flag_q      <= '0;
         flag_cnt_q  <= '0;
         ref_hi_q    <= '0;
         copy_left_q <= '0;
         disp_q      <= '0;
         err_q       <= 1'b0;
      end else if (start) begin
         state_q     <= ST_HDR;
         hdr_cnt_q   <= '0;
         len_q       <= '0;
         out_cnt_q   <= '0;
         flag_q      <= '0;
         flag_cnt_q  <= '0;
         copy_left_q <= '0;
         disp_q      <= '0;
         err_q       <= 1'b0;
      end else begin
         unique case (state_q)
            ST_HDR: begin
               if (accept_in) begin
                  hdr_cnt_q <= hdr_cnt_q + 1'b1;
                  if (hdr_cnt_q != 2'd0) begin
                     len_q <= len_hdr;
                  end
                  if (hdr_cnt_q == 2'd3) begin
                     state_q <= (len_hdr == '0) ? ST_DONE : ST_FLAG;
                  end
               end
            end
            ST_FLAG: begin
               if (accept_in) begin
                  flag_q     <= in_data;
                  flag_cnt_q <= 4'd8;
                  state_q    <= ST_TOKEN;
               end
            end
            ST_TOKEN: begin
               if (flag_q[7]) begin
                  if (accept_in) begin
                     ref_hi_q <= in_data;
                     state_q  <= ST_REFLO;
                  end
               end else if (produce) begin
                  out_cnt_q <= cnt_next;
                  if (byte_last) begin
                     state_q <= ST_DONE;
                  end else begin
                     flag_q     <= {flag_q[6:0], 1'b0};
                     flag_cnt_q <= flag_cnt_q - 1'b1;
                     state_q    <= tok_next;
                  end
               end
            end
            ST_REFLO: begin
               if (accept_in) begin
                  copy_left_q <= CW'(tok_word[TOK_W-1 -: LZI_TOK_LEN_W]) + CW'(LZI_MIN_COPY);
                  disp_q      <= DW'(tok_word[LZI_TOK_DIST_W-1:0]) + 1'b1;
                  state_q     <= ST_COPY;
               end
            end
            ST_COPY: begin
               if (produce) begin
                  out_cnt_q   <= cnt_next;
                  copy_left_q <= copy_left_q - 1'b1;
                  if (byte_last) begin
                     state_q <= ST_DONE;
                     err_q   <= (copy_left_q != CW'(1));
                  end else if (copy_left_q == CW'(1)) begin
                     flag_q     <= {flag_q[6:0], 1'b0};
                     flag_cnt_q <= flag_cnt_q - 1'b1;
                     state_q    <= tok_next;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R9
   copy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COPY) |-> !in_ready);

   // R13
   err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

   // R13
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q inside {ST_FLAG, ST_TOKEN, ST_REFLO, ST_COPY}) |-> (out_cnt_q < len_q));

   // R8
   err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> $past(state_q == ST_COPY));

endmodule

// File: rtl/lzi_out_pack.sv
module lzi_out_pack #(
   parameter bit HALF_EN = 1'b1,
   parameter int OUT_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             half_mode,
   input  logic             byte_vld,
   input  logic [7:0]       byte_dat,
   input  logic             byte_pos0,
   input  logic             byte_last,
   output logic             byte_rdy,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OUT_W-1:0] out_data
);

   localparam int HI_W = OUT_W - 8;

   logic             half_eff;
   logic             slot_free;
   logic             hold_only;
   logic [7:0]       hold_q;
   logic             ov_q;
   logic [OUT_W-1:0] od_q;
   logic [OUT_W-1:0] od_next;

   generate
      if (HALF_EN) begin : g_half
         assign half_eff = half_mode;
      end else begin : g_byte_only
         assign half_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      slot_free = !ov_q || out_ready;
      hold_only = half_eff && !byte_pos0 && !byte_last;
      byte_rdy  = hold_only || slot_free;
      if (half_eff && byte_pos0) begin
         od_next = {HI_W'(byte_dat), hold_q};
      end else begin
         od_next = {{HI_W{1'b0}}, byte_dat};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_q   <= 1'b0;
         od_q   <= '0;
         hold_q <= '0;
      end else if (clr) begin
         ov_q   <= 1'b0;
         hold_q <= '0;
      end else begin
         if (ov_q && out_ready) begin
            ov_q <= 1'b0;
         end
         if (byte_vld && byte_rdy) begin
            if (hold_only) begin
               hold_q <= byte_dat;
            end else begin
               ov_q <= 1'b1;
               od_q <= od_next;
            end
         end
      end
   end

   assign out_valid = ov_q;
   assign out_data  = od_q;

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/lz_stream_inflate.sv
module lz_stream_inflate
   import lzi_pkg::*;
#(
   parameter int HIST_AW = 12,
   parameter bit HALF_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        half_mode,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   output logic        in_ready,
   output logic        out_valid,
   output logic [15:0] out_data,
   input  logic        out_ready,
   output logic        done,
   output logic        error
);

   localparam int OUT_W = 16;

   generate
      if (HIST_AW < LZI_TOK_DIST_W || HIST_AW > LZI_LEN_W) begin : g_bad_aw
         $error("history address width must cover the 12-bit distance and fit the length");
      end
   endgenerate

   logic               byte_vld;
   logic [7:0]         byte_dat;
   logic               byte_rdy;
   logic               byte_last;
   logic               byte_pos0;
   logic               hist_wr_en;
   logic [HIST_AW-1:0] hist_wr_addr;
   logic [7:0]         hist_wr_data;
   logic [HIST_AW-1:0] hist_rd_addr;
   logic [7:0]         hist_rd_data;

   lzi_ctrl #(
      .HIST_AW(HIST_AW)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .in_ready    (in_ready),
      .byte_vld    (byte_vld),
      .byte_dat    (byte_dat),
      .byte_rdy    (byte_rdy),
      .byte_last   (byte_last),
      .byte_pos0   (byte_pos0),
      .hist_wr_en  (hist_wr_en),
      .hist_wr_addr(hist_wr_addr),
      .hist_wr_data(hist_wr_data),
      .hist_rd_addr(hist_rd_addr),
      .hist_rd_data(hist_rd_data),
      .done        (done),
      .error       (error)
   );

   lzi_hist_ram #(
      .ADDR_W(HIST_AW),
      .DATA_W(8)
   ) u_hist (
      .clk    (clk),
      .wr_en  (hist_wr_en),
      .wr_addr(hist_wr_addr),
      .wr_data(hist_wr_data),
      .rd_addr(hist_rd_addr),
      .rd_data(hist_rd_data)
   );

   lzi_out_pack #(
      .HALF_EN(HALF_EN),
      .OUT_W  (OUT_W)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .half_mode(half_mode),
      .byte_vld (byte_vld),
      .byte_dat (byte_dat),
      .byte_pos0(byte_pos0),
      .byte_last(byte_last),
      .byte_rdy (byte_rdy),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_data (out_data)
   );

endmodule

// File: tb/lz_stream_inflate_bench.sv
module lz_stream_inflate_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        half_mode = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready;
   logic        out_valid;
   logic [15:0] out_data;
   logic        out_ready = 1'b0;
   logic        done;
   logic        error;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string cur_req = "R1";

   logic [7:0]  stim_q [$];
   logic [15:0] exp_q [$];
   logic [7:0]  lfsr = 8'hA5;
   logic        prev_stall = 1'b0;
   logic [15:0] prev_data = '0;
   logic [7:0]  lit_hist [$];

   always #4 clk = ~clk;

   lz_stream_inflate u_lz_stream_inflate (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .half_mode(half_mode),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_ready(out_ready),
      .done     (done),
      .error    (error)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // monitor / scoreboard: decides out_ready for the next edge, pops on transfer
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall) begin
            // R10
            chk(out_valid && (out_data == prev_data), "R10", {15'd0, out_valid, out_data}, {15'd0, 1'b1, prev_data});
         end
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         out_ready = lfsr[0] | lfsr[1];
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, cur_req, {16'd0, out_data}, 32'hFFFF_FFFF);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk(out_data == e, cur_req, {16'd0, out_data}, {16'd0, e});
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic push_hdr(input int len, input logic [7:0] typ);
      stim_q.push_back(typ);
      stim_q.push_back(len[7:0]);
      stim_q.push_back(len[15:8]);
      stim_q.push_back(len[23:16]);
   endtask

   task automatic exp_b(input logic [7:0] b);
      exp_q.push_back({8'h00, b});
   endtask

   task automatic send_stream();
      while (stim_q.size() > 0) begin
         in_valid = 1'b1;
         in_data  = stim_q.pop_front();
         #1;
         while (!in_ready) begin
            @(negedge clk);
            #1;
         end
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic run_case(input string req, input bit half, input bit exp_err, input bit chk_stall);
      int w;
      cur_req = req;
      @(negedge clk);
      half_mode = half;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      send_stream();
      if (chk_stall) begin
         #1;
         // R9: last input byte was a reference, copy in progress
         chk(!in_ready && !done, "R9", {30'd0, in_ready, done}, 32'd0);
      end
      w = 0;
      while (!done && w < 5000) begin
         @(negedge clk);
         w++;
      end
      w = 0;
      while (exp_q.size() > 0 && w < 5000) begin
         @(negedge clk);
         w++;
      end
      #1;
      // R13
      chk(done == 1'b1, "R13", {31'd0, done}, 32'd1);
      chk(exp_q.size() == 0, req, exp_q.size(), 32'd0);
      // R8
      chk(error == exp_err, "R8", {31'd0, error}, {31'd0, exp_err});
      // R7: further input is refused after the length is reached
      in_valid = 1'b1;
      in_data  = 8'h3C;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         #1;
         chk(!in_ready && done, "R7", {30'd0, in_ready, done}, 32'd1);
      end
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1
      chk(!in_ready && !out_valid && !done && !error, "R1",
          {28'd0, in_ready, out_valid, done, error}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(!in_ready && !out_valid && !done && !error, "R1",
          {28'd0, in_ready, out_valid, done, error}, 32'd0);

      // R4: literals only, unused flag bits afterwards
      push_hdr(5, 8'h10);
      stim_q.push_back(8'h00);
      for (int i = 0; i < 5; i++) begin
         stim_q.push_back(8'hA0 + 8'(i));
         exp_b(8'hA0 + 8'(i));
      end
      run_case("R4", 1'b0, 1'b0, 1'b0);

      // R6: displacement 1, length 9 -> run of one byte
      push_hdr(10, 8'h10);
      stim_q.push_back(8'h40);
      stim_q.push_back(8'h11);
      stim_q.push_back(8'h60);
      stim_q.push_back(8'h00);
      for (int i = 0; i < 10; i++) exp_b(8'h11);
      run_case("R6", 1'b0, 1'b0, 1'b1);

      // R5: three literals, then reference length 3 displacement 3, exact end
      push_hdr(6, 8'h10);
      stim_q.push_back(8'h10);
      stim_q.push_back(8'h01);
      stim_q.push_back(8'h02);
      stim_q.push_back(8'h03);
      stim_q.push_back(8'h00);
      stim_q.push_back(8'h02);
      exp_b(8'h01); exp_b(8'h02); exp_b(8'h03);
      exp_b(8'h01); exp_b(8'h02); exp_b(8'h03);
      run_case("R5", 1'b0, 1'b0, 1'b1);

      // R8: reference of 5 cut to 3 bytes by the length
      push_hdr(4, 8'h10);
      stim_q.push_back(8'h40);
      stim_q.push_back(8'h55);
      stim_q.push_back(8'h20);
      stim_q.push_back(8'h00);
      for (int i = 0; i < 4; i++) exp_b(8'h55);
      run_case("R8", 1'b0, 1'b1, 1'b0);

      // R12: halfword packing, even length
      push_hdr(6, 8'h10);
      stim_q.push_back(8'h10);
      stim_q.push_back(8'h01);
      stim_q.push_back(8'h02);
      stim_q.push_back(8'h03);
      stim_q.push_back(8'h00);
      stim_q.push_back(8'h02);
      exp_q.push_back(16'h0201);
      exp_q.push_back(16'h0103);
      exp_q.push_back(16'h0302);
      run_case("R12", 1'b1, 1'b0, 1'b1);

      // R12: halfword packing, odd length ends with a lone low byte
      push_hdr(5, 8'h10);
      stim_q.push_back(8'h00);
      for (int i = 0; i < 5; i++) stim_q.push_back(8'hA0 + 8'(i));
      exp_q.push_back(16'hA1A0);
      exp_q.push_back(16'hA3A2);
      exp_q.push_back(16'h00A4);
      run_case("R12", 1'b1, 1'b0, 1'b0);

      // R3 / R2: two flag groups, type byte 0xFF ignored, byte mode (R11)
      push_hdr(10, 8'hFF);
      stim_q.push_back(8'h00);
      for (int i = 0; i < 8; i++) begin
         stim_q.push_back(8'hC0 + 8'(i));
         exp_b(8'hC0 + 8'(i));
      end
      stim_q.push_back(8'h00);
      stim_q.push_back(8'hE1); exp_b(8'hE1);
      stim_q.push_back(8'hE2); exp_b(8'hE2);
      run_case("R3", 1'b0, 1'b0, 1'b0);

      // R2: zero length gives done and no output
      push_hdr(0, 8'h10);
      run_case("R2", 1'b0, 1'b0, 1'b0);

      // R5: long distance uses the high nibble of the distance (300 back)
      lit_hist.delete();
      push_hdr(303, 8'h10);
      for (int t = 0; t < 301; t++) begin
         if (t % 8 == 0) stim_q.push_back((t == 296) ? 8'h08 : 8'h00);
         if (t < 300) begin
            logic [7:0] b;
            b = 8'(t) ^ 8'h5A;
            stim_q.push_back(b);
            lit_hist.push_back(b);
            exp_b(b);
         end else begin
            stim_q.push_back(8'h01);
            stim_q.push_back(8'h2B);
         end
      end
      exp_b(lit_hist[0]); exp_b(lit_hist[1]); exp_b(lit_hist[2]);
      run_case("R5", 1'b0, 1'b0, 1'b1);

      // R11: byte mode after halfword runs, literal then distance-2 copy
      push_hdr(7, 8'h10);
      stim_q.push_back(8'h20);
      stim_q.push_back(8'h7E);
      stim_q.push_back(8'h7F);
      stim_q.push_back(8'h20);
      stim_q.push_back(8'h01);
      exp_b(8'h7E); exp_b(8'h7F); exp_b(8'h7E); exp_b(8'h7F);
      exp_b(8'h7E); exp_b(8'h7F); exp_b(8'h7E);
      run_case("R11", 1'b0, 1'b0, 1'b1);

      // R1: start while done clears done and error
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1;
      chk(!done && !error && in_ready, "R1", {29'd0, done, error, in_ready}, 32'd1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule